// File: doc/BRIEF.md
# Serial EEPROM Configuration Loader

This block brings a host adapter's stored configuration in from a serial EEPROM after a start request. A word-read port with a request/valid handshake stands in for the EEPROM. The loader fetches a 32-word image of 16-bit words and keeps a wrap-around sum of every word except the last. It then compares that sum with the last word. When the sum matches, the loader turns the packed per-target flag words into settings bytes and writes them to a small scratch RAM port, one byte per cycle. It also presents the host ID, a SCSI configuration byte, disconnect-disable bytes, a termination flag and an Ultra enable.

If the sum does not match, or the EEPROM refuses a read, the loader skips every scratch write. It then presents a fixed set of default values and raises a defaults flag. A channel select picks one of three 32-word images stored back to back in the EEPROM.

Top module: `cfgld_loader`

## Requirements
- R1: A start seen while idle begins a fetch of words 0 to 31 in ascending order, with one request outstanding at a time. The word address is base + k, where base is 32 × channel. While rd_valid and rd_nack are both low, rd_req stays high and rd_addr holds its value.
- R2: The image is valid when the 16-bit wrap-around sum of words 0 to 30 equals word 31. Any other value selects the defaults.
- R3: A rd_nack during a fetch ends the fetch at once and selects the defaults.
- R4: On a valid image, settings bytes are written to scratch addresses 0 up to lim−1 in ascending order, one per cycle, where lim = min(word19[7:0], 16). The byte for target i has bit 7 = flag bit 5 (wide), bits 6:4 = flag bits 2:0 (rate) and bit 0 = flag bit 3 (sync). All other bits are zero. Flag word i is image word i.
- R5: The disconnect mask has bit i = flag bit 4 of target i, for i < lim, and 0 otherwise. disc_dis_lo = ~mask[7:0] and disc_dis_hi = ~mask[15:8].
- R6: host_id = word18[3:0]. In scsi_cfg, bits 2:0 = word18[2:0], bit 4 = word17 bit 4 (parity check) and bit 6 = word17 bit 6 (bus reset at boot). All other bits are zero.
- R7: ultra_en = ultra_cap AND word17 bit 1. term_low = word17 bit 2.
- R8: The defaults are: defaults_valid = 1, host_id = 7, scsi_cfg = 0x57, both disable bytes = 0xFF, term_low = 1, ultra_en = ultra_cap, and no scratch writes.
- R9: done is a one-cycle pulse. All decoded outputs take their new values in the cycle done is high. busy is high from the cycle after an accepted start through the done cycle. A start while busy, including during the done cycle, is ignored.
- R10: After reset, busy, done, rd_req, scr_we and every decoded output are zero.
- R11: A channel select of 3 is treated as channel 2, so base = 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a load (taken only when idle) |
| chan_sel | input | 2 | Image select, 0 to 2 |
| ultra_cap | input | 1 | The part can run Ultra speed |
| rd_req | output | 1 | Word read request |
| rd_addr | output | 7 | Word read address |
| rd_valid | input | 1 | Read data returned |
| rd_nack | input | 1 | Read refused / no EEPROM |
| rd_data | input | 16 | Read word |
| scr_we | output | 1 | Scratch RAM write strobe |
| scr_addr | output | 4 | Scratch RAM target index |
| scr_wdata | output | 8 | Target settings byte |
| busy | output | 1 | Load in progress |
| done | output | 1 | Load finished pulse |
| defaults_valid | output | 1 | Defaults in use |
| host_id | output | 4 | Host SCSI ID |
| scsi_cfg | output | 8 | SCSI configuration byte |
| disc_dis_lo | output | 8 | Disconnect disable, targets 0–7 |
| disc_dis_hi | output | 8 | Disconnect disable, targets 8–15 |
| term_low | output | 1 | Low-byte termination enable |
| ultra_en | output | 1 | Ultra speed enabled |

## Verification
Two events can fall in the same cycle: the done pulse that closes a load and a fresh start request. The bench asserts start exactly in the cycle where done is high. It then requires that rd_req stays low afterwards and that the reference model, which only accepts starts while idle, agrees cycle by cycle. A second start pulse in the middle of a fetch checks that the address sequence carries on unchanged.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;
  localparam int WORD_W    = 16;
  localparam int FLAG_W    = 6;
  localparam int ADAPT_IDX = 17;
  localparam int ID_IDX    = 18;
  localparam int MAXT_IDX  = 19;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_WRITE, S_FIN} ld_state_e;

  // wide -> bit 7, rate -> bits 6:4, sync -> bit 0
  function automatic logic [7:0] tgt_settings(input logic [FLAG_W-1:0] f);
    return {f[5], f[2:0], 3'b000, f[3]};
  endfunction

  function automatic logic [7:0] cfg_byte(input logic [3:0] id, input logic par,
                                          input logic brst);
    return {1'b0, brst, 1'b0, par, 1'b0, id[2:0]};
  endfunction

  function automatic logic [WORD_W-1:0] add16(input logic [WORD_W-1:0] a,
                                              input logic [WORD_W-1:0] b);
    return a + b;
  endfunction
endpackage

// File: rtl/cfgld_fetch.sv
module cfgld_fetch #(
  parameter int WORDS  = 32,
  parameter int NCHAN  = 3,
  parameter int ADDR_W = 7,
  parameter int CH_W   = 2,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [CH_W-1:0]   chan,
  input  logic              rd_valid,
  input  logic              rd_nack,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              word_stb,
  output logic              last_stb,
  output logic              abort_stb,
  output logic [IDX_W-1:0]  word_idx
);
  logic              active_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] base_q;
  logic [CH_W-1:0]   ch_eff;

  assign ch_eff    = (chan > CH_W'(NCHAN - 1)) ? CH_W'(NCHAN - 1) : chan;
  assign rd_req    = active_q;
  assign rd_addr   = base_q + ADDR_W'(idx_q);
  assign word_idx  = idx_q;
  assign word_stb  = active_q && rd_valid;
  assign abort_stb = active_q && !rd_valid && rd_nack;
  assign last_stb  = word_stb && (idx_q == IDX_W'(WORDS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      base_q   <= '0;
    end else if (go) begin
      active_q <= 1'b1;
      idx_q    <= '0;
      base_q   <= ADDR_W'(ch_eff) * ADDR_W'(WORDS);
    end else if (last_stb || abort_stb) begin
      active_q <= 1'b0;
    end else if (word_stb) begin
      idx_q <= idx_q + 1'b1;
    end
  end

  // R1: a waiting request keeps its address
  a_r1_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_valid && !rd_nack && !go) |=> (rd_req && $stable(rd_addr)));
  // R1: accepted word advances the address by one
  a_r1_next_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (word_stb && !last_stb) |=> (rd_req && rd_addr == $past(rd_addr) + 1'b1));
  // R3: a refusal ends the fetch
  a_r3_abort_stop: assert property (@(posedge clk) disable iff (!rst_n)
    abort_stb |=> !rd_req);
endmodule

// File: rtl/cfgld_image.sv
module cfgld_image
  import cfgld_pkg::*;
#(
  parameter int NTARG  = 16,
  parameter int IDX_W  = 5,
  localparam int TGT_AW = $clog2(NTARG),
  localparam int LIM_W  = $clog2(NTARG + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              word_stb,
  input  logic              last_stb,
  input  logic [IDX_W-1:0]  word_idx,
  input  logic [WORD_W-1:0] word_data,
  input  logic [TGT_AW-1:0] rd_tgt,
  output logic              sum_ok,
  output logic [LIM_W-1:0]  lim,
  output logic [NTARG-1:0]  disc_mask,
  output logic [7:0]        tgt_byte,
  output logic [3:0]        id_q,
  output logic [3:0]        ctl_q   // {bus reset, parity, term low, ultra}
);
  logic [WORD_W-1:0] sum_q;
  logic [7:0]        maxt_q;
  logic [FLAG_W-1:0] flags_w [NTARG];

  assign sum_ok = (sum_q == word_data);
  assign lim    = (maxt_q >= 8'(NTARG)) ? LIM_W'(NTARG) : LIM_W'(maxt_q);

  for (genvar t = 0; t < NTARG; t++) begin : g_tgt
    logic [FLAG_W-1:0] f_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    f_q <= '0;
      else if (word_stb && word_idx == IDX_W'(t))    f_q <= word_data[FLAG_W-1:0];
    end
    assign flags_w[t]   = f_q;
    assign disc_mask[t] = f_q[4] && (LIM_W'(t) < lim);
  end

  assign tgt_byte = tgt_settings(flags_w[rd_tgt]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q  <= '0;
      maxt_q <= '0;
      id_q   <= '0;
      ctl_q  <= '0;
    end else if (clear) begin
      sum_q <= '0;
    end else if (word_stb) begin
      if (!last_stb) sum_q <= add16(sum_q, word_data);
      if (word_idx == IDX_W'(ADAPT_IDX))
        ctl_q <= {word_data[6], word_data[4], word_data[2], word_data[1]};
      if (word_idx == IDX_W'(ID_IDX))   id_q   <= word_data[3:0];
      if (word_idx == IDX_W'(MAXT_IDX)) maxt_q <= word_data[7:0];
    end
  end
endmodule

// File: rtl/cfgld_loader.sv
module cfgld_loader
  import cfgld_pkg::*;
#(
  parameter int NTARG     = 16,
  parameter int IMG_WORDS = 32,
  parameter int NCHAN     = 3,
  localparam int ADDR_W = $clog2(NCHAN * IMG_WORDS),
  localparam int CH_W   = $clog2(NCHAN),
  localparam int TGT_AW = $clog2(NTARG),
  localparam int LIM_W  = $clog2(NTARG + 1),
  localparam int IDX_W  = $clog2(IMG_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CH_W-1:0]   chan_sel,
  input  logic              ultra_cap,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_valid,
  input  logic              rd_nack,
  input  logic [WORD_W-1:0] rd_data,
  output logic              scr_we,
  output logic [TGT_AW-1:0] scr_addr,
  output logic [7:0]        scr_wdata,
  output logic              busy,
  output logic              done,
  output logic              defaults_valid,
  output logic [3:0]        host_id,
  output logic [7:0]        scsi_cfg,
  output logic [7:0]        disc_dis_lo,
  output logic [7:0]        disc_dis_hi,
  output logic              term_low,
  output logic              ultra_en
);
  ld_state_e         state_q, state_d;
  logic [TGT_AW-1:0] wi_q;
  logic              go, word_stb, last_stb, abort_stb, sum_ok, wr_last;
  logic              load_img, load_dflt;
  logic [IDX_W-1:0]  word_idx;
  logic [LIM_W-1:0]  lim;
  logic [NTARG-1:0]  disc_mask;
  logic [15:0]       mask16;
  logic [3:0]        id_q, ctl_q;

  assign go = start && (state_q == S_IDLE);

  cfgld_fetch #(.WORDS(IMG_WORDS), .NCHAN(NCHAN), .ADDR_W(ADDR_W), .CH_W(CH_W)) u_fetch (
    .clk(clk), .rst_n(rst_n), .go(go), .chan(chan_sel), .rd_valid(rd_valid),
    .rd_nack(rd_nack), .rd_req(rd_req), .rd_addr(rd_addr), .word_stb(word_stb),
    .last_stb(last_stb), .abort_stb(abort_stb), .word_idx(word_idx));

  cfgld_image #(.NTARG(NTARG), .IDX_W(IDX_W)) u_image (
    .clk(clk), .rst_n(rst_n), .clear(go), .word_stb(word_stb), .last_stb(last_stb),
    .word_idx(word_idx), .word_data(rd_data), .rd_tgt(wi_q), .sum_ok(sum_ok),
    .lim(lim), .disc_mask(disc_mask), .tgt_byte(scr_wdata), .id_q(id_q), .ctl_q(ctl_q));

  assign wr_last   = (LIM_W'(wi_q) + 1'b1 == lim);
  assign load_img  = ((state_q == S_FETCH) && last_stb && sum_ok && lim == '0) ||
                     ((state_q == S_WRITE) && wr_last);
  assign load_dflt = (state_q == S_FETCH) && ((last_stb && !sum_ok) || abort_stb);
  assign mask16    = 16'(disc_mask);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:  if (go) state_d = S_FETCH;
      S_FETCH: if (last_stb && sum_ok && lim != '0) state_d = S_WRITE;
               else if (load_img || load_dflt)      state_d = S_FIN;
      S_WRITE: if (wr_last) state_d = S_FIN;
      S_FIN:   state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      wi_q    <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == S_WRITE) wi_q <= wi_q + 1'b1;
      else                    wi_q <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      defaults_valid <= 1'b0; host_id <= '0; scsi_cfg <= '0;
      disc_dis_lo <= '0; disc_dis_hi <= '0; term_low <= 1'b0; ultra_en <= 1'b0;
    end else if (load_img) begin
      defaults_valid <= 1'b0;
      host_id        <= id_q;
      scsi_cfg       <= cfg_byte(id_q, ctl_q[2], ctl_q[3]);
      disc_dis_lo    <= ~mask16[7:0];
      disc_dis_hi    <= ~mask16[15:8];
      term_low       <= ctl_q[1];
      ultra_en       <= ultra_cap && ctl_q[0];
    end else if (load_dflt) begin
      defaults_valid <= 1'b1;
      host_id        <= 4'd7;
      scsi_cfg       <= cfg_byte(4'd7, 1'b1, 1'b1);
      disc_dis_lo    <= 8'hFF;
      disc_dis_hi    <= 8'hFF;
      term_low       <= 1'b1;
      ultra_en       <= ultra_cap;
    end
  end

  assign scr_we   = (state_q == S_WRITE);
  assign scr_addr = wi_q;
  assign busy     = (state_q != S_IDLE);
  assign done     = (state_q == S_FIN);

  // R9: done lasts a single cycle
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R9: a start in the done cycle does not begin a fetch
  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n) done |=> !rd_req);
  // R4: scratch writes never overlap the fetch or the done pulse
  a_r4_write_excl: assert property (@(posedge clk) disable iff (!rst_n)
    scr_we |-> (!rd_req && !done));
  // R8: a defaults result is never preceded by a scratch write
  a_r8_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (done && defaults_valid) |-> !$past(scr_we));
endmodule

// File: tb/cfgld_loader_tb_top.sv
module cfgld_loader_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0, ultra_cap = 1'b0;
  logic [1:0]  chan_sel = 2'd0;
  logic        rd_valid = 1'b0, rd_nack = 1'b0;
  logic [15:0] rd_data = '0;
  logic        rd_req, scr_we, busy, done, defaults_valid, term_low, ultra_en;
  logic [6:0]  rd_addr;
  logic [3:0]  scr_addr, host_id;
  logic [7:0]  scr_wdata, scsi_cfg, disc_dis_lo, disc_dis_hi;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgld_loader dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .chan_sel(chan_sel), .ultra_cap(ultra_cap),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_nack(rd_nack),
    .rd_data(rd_data), .scr_we(scr_we), .scr_addr(scr_addr), .scr_wdata(scr_wdata),
    .busy(busy), .done(done), .defaults_valid(defaults_valid), .host_id(host_id),
    .scsi_cfg(scsi_cfg), .disc_dis_lo(disc_dis_lo), .disc_dis_hi(disc_dis_hi),
    .term_low(term_low), .ultra_en(ultra_en));

  int compared = 0, mismatched = 0;
  logic [15:0] eeprom [96];
  int lat = 1, nack_word = -1, wait_cnt = 0;
  int nwr = 0;
  int seen [16];

  task automatic chk(string tag, string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // EEPROM responder
  always @(negedge clk) begin
    if (rd_valid || rd_nack) begin
      rd_valid <= 1'b0; rd_nack <= 1'b0; wait_cnt <= lat;
    end else if (rd_req) begin
      if (wait_cnt == 0) begin
        if ((int'(rd_addr) % 32) == nack_word) rd_nack <= 1'b1;
        else begin rd_valid <= 1'b1; rd_data <= eeprom[rd_addr]; end
      end else wait_cnt <= wait_cnt - 1;
    end
  end

  // behavioural reference model
  int m_phase = 0, m_k = 0, m_base = 0, m_wi = 0, m_lim = 0;
  int m_img [32];
  int m_sum = 0;
  int e_dflt = 0, e_id = 0, e_cfg = 0, e_dlo = 0, e_dhi = 0, e_term = 0, e_ultra = 0;

  function automatic int m_set(int f);
    int r = 0;
    if (f & 8)  r += 1;
    if (f & 32) r += 128;
    r += (f & 7) * 16;
    return r;
  endfunction

  task automatic m_load_img();
    int mask = 0;
    for (int i = 0; i < m_lim; i++) if ((m_img[i] >> 4) & 1) mask += (1 << i);
    e_dflt = 0;
    e_id   = m_img[18] % 16;
    e_cfg  = (m_img[18] % 8) + (((m_img[17] >> 4) & 1) * 16) + (((m_img[17] >> 6) & 1) * 64);
    e_dlo  = 255 - (mask % 256);
    e_dhi  = 255 - (mask / 256);
    e_term = (m_img[17] >> 2) & 1;
    e_ultra = (ultra_cap && ((m_img[17] >> 1) & 1)) ? 1 : 0;
  endtask

  task automatic m_load_dflt();
    e_dflt = 1; e_id = 7; e_cfg = 'h57; e_dlo = 255; e_dhi = 255; e_term = 1;
    e_ultra = ultra_cap ? 1 : 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_k = 0; m_wi = 0;
      e_dflt = 0; e_id = 0; e_cfg = 0; e_dlo = 0; e_dhi = 0; e_term = 0; e_ultra = 0;
    end else begin
      case (m_phase)
        0: if (start) begin
             m_phase = 1; m_k = 0; m_sum = 0;
             m_base = (chan_sel == 2'd3 ? 2 : int'(chan_sel)) * 32;
           end
        1: if (rd_valid) begin
             m_img[m_k] = int'(rd_data);
             if (m_k < 31) begin
               m_sum = (m_sum + int'(rd_data)) % 65536;
               m_k++;
             end else if (m_sum == int'(rd_data)) begin
               m_lim = (m_img[19] % 256) > 16 ? 16 : (m_img[19] % 256);
               if (m_lim > 0) begin m_phase = 2; m_wi = 0; end
               else begin m_load_img(); m_phase = 3; end
             end else begin m_load_dflt(); m_phase = 3; end
           end else if (rd_nack) begin m_load_dflt(); m_phase = 3; end
        2: if (m_wi == m_lim - 1) begin m_load_img(); m_phase = 3; end
           else m_wi++;
        default: m_phase = 0;
      endcase
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R1", "rd_req", int'(rd_req), int'(m_phase == 1));
      if (m_phase == 1) chk("R1", "rd_addr", int'(rd_addr), m_base + m_k);
      chk("R4", "scr_we", int'(scr_we), int'(m_phase == 2));
      if (m_phase == 2) begin
        chk("R4", "scr_addr", int'(scr_addr), m_wi);
        chk("R4", "scr_wdata", int'(scr_wdata), m_set(m_img[m_wi]));
      end
      chk("R9", "done", int'(done), int'(m_phase == 3));
      chk("R9", "busy", int'(busy), int'(m_phase != 0));
      chk("R8", "defaults_valid", int'(defaults_valid), e_dflt);
      chk("R6", "host_id", int'(host_id), e_id);
      chk("R6", "scsi_cfg", int'(scsi_cfg), e_cfg);
      chk("R5", "disc_dis_lo", int'(disc_dis_lo), e_dlo);
      chk("R5", "disc_dis_hi", int'(disc_dis_hi), e_dhi);
      chk("R7", "term_low", int'(term_low), e_term);
      chk("R7", "ultra_en", int'(ultra_en), e_ultra);
      if (scr_we) begin seen[scr_addr] = int'(scr_wdata); nwr++; end
    end
  end

  task automatic put_image(int slot, int seed, int maxt, int adapt, int idw, bit bad);
    int s = 0;
    for (int k = 0; k < 31; k++) begin
      int w;
      if (k == 17)      w = adapt;
      else if (k == 18) w = idw;
      else if (k == 19) w = maxt;
      else              w = (seed * 29 + k * 13 + k * k * 7) % 65536;
      eeprom[slot * 32 + k] = 16'(w);
      s = (s + w) % 65536;
    end
    eeprom[slot * 32 + 31] = 16'(bad ? (s ^ 1) : s);
  endtask

  task automatic run(int ch, bit pulse_mid, bit pulse_done);
    int guard = 0;
    nwr = 0;
    for (int i = 0; i < 16; i++) seen[i] = -1;
    @(negedge clk); chan_sel = 2'(ch); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (pulse_mid) begin
      repeat (5) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    while (!done && guard < 2000) begin @(negedge clk); guard++; end
    if (pulse_done) begin
      start = 1'b1; @(negedge clk); start = 1'b0;
      for (int i = 0; i < 4; i++) begin
        chk("R9", "start at done ignored", int'(rd_req), 0);
        @(negedge clk);
      end
    end else @(negedge clk);
  endtask

  task automatic check_writes(int slot, int lim);
    chk("R4", "write count", nwr, lim);
    for (int i = 0; i < lim; i++) begin
      int f = int'(eeprom[slot * 32 + i]);
      chk("R4", "settings byte", seen[i], m_set(f));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int i = 0; i < 96; i++) eeprom[i] = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", "busy", int'(busy), 0);
    chk("R10", "done", int'(done), 0);
    chk("R10", "rd_req", int'(rd_req), 0);
    chk("R10", "scr_we", int'(scr_we), 0);
    chk("R10", "outputs", int'({defaults_valid, host_id, scsi_cfg, disc_dis_lo,
                                disc_dis_hi, term_low, ultra_en}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // valid image, four targets, R2 R6 R7
    ultra_cap = 1'b1; lat = 1;
    put_image(0, 3, 4, 'h0056, 'hA0B, 1'b0);
    run(0, 1'b0, 1'b0);
    chk("R2", "valid image", int'(defaults_valid), 0);
    chk("R6", "host id", int'(host_id), 'hB);
    chk("R6", "cfg byte", int'(scsi_cfg), 'h53);
    chk("R7", "ultra on", int'(ultra_en), 1);
    chk("R7", "term low", int'(term_low), 1);
    check_writes(0, 4);

    // channel 1, count above 16 clamps, ultra bit clear
    lat = 0;
    put_image(1, 11, 'h20, 'h0001, 'h0005, 1'b0);
    run(1, 1'b0, 1'b0);
    chk("R7", "ultra gated off", int'(ultra_en), 0);
    check_writes(1, 16);

    // bad checksum -> defaults
    put_image(2, 5, 6, 'h0052, 'h0003, 1'b1);
    run(2, 1'b0, 1'b0);
    chk("R2", "bad sum -> defaults", int'(defaults_valid), 1);
    chk("R8", "default id", int'(host_id), 7);
    chk("R8", "default cfg", int'(scsi_cfg), 'h57);
    chk("R8", "no writes", nwr, 0);

    // refused read -> defaults
    lat = 2; nack_word = 10;
    put_image(0, 8, 4, 'h0002, 'h0004, 1'b0);
    run(0, 1'b0, 1'b0);
    chk("R3", "nack -> defaults", int'(defaults_valid), 1);
    chk("R3", "no writes", nwr, 0);
    nack_word = -1;

    // channel select 3 reads slot 2, zero targets
    lat = 1; ultra_cap = 1'b0;
    put_image(2, 21, 0, 'h0044, 'h000E, 1'b0);
    run(3, 1'b0, 1'b0);
    chk("R11", "chan 3 image valid", int'(defaults_valid), 0);
    chk("R11", "chan 3 host id", int'(host_id), 'hE);
    chk("R5", "no targets mask lo", int'(disc_dis_lo), 'hFF);
    check_writes(2, 0);

    // start during fetch and at done are ignored
    put_image(1, 17, 3, 'h0010, 'h0006, 1'b0);
    run(1, 1'b1, 1'b1);
    check_writes(1, 3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule